// File: doc/BRIEF.md
# Interrupt Acknowledge Timing Sequencer

This block sits beside a small multi-cycle processor and decides at which instruction boundary a pending interrupt is taken. It follows the instruction phase interface clock by clock: a strobe marking the first clock of each instruction, that instruction's clock count, and a marker on its final clock. It also follows the request flags, the mask bits and one priority bit per source, plus a strobe saying that the flag or mask registers are being accessed. The request picture is frozen one clock before an instruction ends. A request that first shows up in the final clock therefore waits until one more whole instruction has run.

Once a request is taken, the block runs a fixed acknowledge sequence. It holds the processor with a busy signal, pulses a status-save step and a return-address-save step, presents the winning source index, and pulses a one-hot clear for that source's flag. It keeps track of which priority levels are in service, so a more urgent request can interrupt a service routine. It also keeps a global enable bit, which software sets and the acknowledge clears.

Top module: `irq_ack_seq`

## Requirements
- R1: After reset, `ack_busy`, `save_status`, `save_ret_addr` and `flag_clr` are all low, and the global enable is clear, so no request is taken until `int_enable_set` has pulsed.
- R2: For an instruction of n clocks (2 ≤ n ≤ 10, given on `instr_len` with `instr_start`), an eligible request is taken if it is present in clock n-1. `ack_busy` then rises in the clock after the one where `instr_last` is high.
- R3: A request that first appears in the final clock of an instruction is not taken at that boundary. If it is still eligible, it is taken after the following instruction ends. For a 2-clock instruction, only a request present in its first clock is taken at its end.
- R4: The acknowledge lasts exactly 8 clocks of `ack_busy`. Counting the first busy clock as step 0, `flag_clr` is the one-hot of the winner in step 0 only, `save_status` is high in step 1 only and `save_ret_addr` in step 3 only. `vec_idx` holds the winner for all 8 steps, and no instruction starts while busy.
- R5: A source whose `irq_mask` bit is 1 is never taken. Masking does not remove its request, so clearing the mask later lets it be taken.
- R6: If `flag_access` is high in the sampling clock (clock n-1), nothing is taken at that boundary. The request stays pending and is taken after the next instruction.
- R7: Among eligible sources, a source with its `irq_prio` bit at 1 (high level) beats one with the bit at 0. Within one level, the lowest index wins.
- R8: The global enable is set by a one-clock `int_enable_set` pulse and cleared when an acknowledge starts. While it is clear, no request is taken.
- R9: Nesting: while a low-level service is active, only a high-level request can be taken. While a high-level service is active, none can. An `isr_return` pulse ends the most recently entered service level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_start | input | 1 | First clock of an instruction |
| instr_len | input | 4 | Clock count of the instruction, valid with `instr_start` |
| instr_last | input | 1 | Final clock of the instruction |
| irq_flag | input | 8 | Request flags, one per source |
| irq_mask | input | 8 | Mask bits, 1 = masked |
| irq_prio | input | 8 | Priority level per source, 1 = high |
| flag_access | input | 1 | Flag or mask registers are being accessed |
| int_enable_set | input | 1 | Pulse that sets the global enable |
| isr_return | input | 1 | Pulse that ends the innermost service level |
| ack_busy | output | 1 | Acknowledge sequence active, processor stalled |
| save_status | output | 1 | Step strobe: save the status word |
| save_ret_addr | output | 1 | Step strobe: save the return address |
| vec_idx | output | 3 | Index of the source being acknowledged |
| flag_clr | output | 8 | One-hot clear for the winner's request flag |

## Verification
The bench plays the processor: it drives one clock of an instruction per cycle and raises flags in a chosen phase. The take decision is due in the first clock after the final one, so `ack_busy` is checked right after the edge that closes the final clock. From there, the acknowledge is followed one clock at a time and each step's strobes are compared against its step number 0 to 7. Cases where nothing is taken are checked at that same boundary, and the pending request is then shown to be taken exactly one instruction later. All samples are taken one nanosecond after a rising edge, and inputs change only at that point.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {LVL_NONE = 2'd0, LVL_LO = 2'd1, LVL_HI = 2'd2} svc_lvl_e;

  function automatic svc_lvl_e cur_level(input logic lo, input logic hi);
    if (hi) return LVL_HI;
    if (lo) return LVL_LO;
    return LVL_NONE;
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     flag,
  input  logic [N-1:0]     mask,
  input  logic [N-1:0]     prio,
  input  logic             ie,
  input  irq_seq_pkg::svc_lvl_e level,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx,
  output logic             win_hi
);
  import irq_seq_pkg::*;

  logic [N-1:0] elig, hi_set, lo_set;

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g]   = flag[g] & ~mask[g];
    assign hi_set[g] = elig[g] & prio[g];
    assign lo_set[g] = elig[g] & ~prio[g];
  end

  logic [IDX_W-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hi_set[i]) hi_idx = IDX_W'(i);
      if (lo_set[i]) lo_idx = IDX_W'(i);
    end
  end

  logic hi_ok, lo_ok;
  assign hi_ok = ie && (|hi_set) && (level != LVL_HI);
  assign lo_ok = ie && (|lo_set) && (level == LVL_NONE);

  assign win_valid = hi_ok | lo_ok;
  assign win_hi    = hi_ok;
  assign win_idx   = hi_ok ? hi_idx : lo_idx;
endmodule

// File: rtl/irq_boundary.sv
module irq_boundary #(
  parameter int LEN_W   = 4,
  parameter int IDX_W   = 3,
  parameter int MIN_LEN = 2,
  parameter int MAX_LEN = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_start,
  input  logic [LEN_W-1:0] instr_len,
  input  logic             instr_last,
  input  logic             flag_access,
  input  logic             win_valid,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             win_hi,
  output logic             take,
  output logic [IDX_W-1:0] take_idx,
  output logic             take_hi
);
  logic [LEN_W-1:0] phase_q, len_q, phase_cur, len_cur, samp_ph, last_ph;
  logic             in_instr_q, active, samp_now;
  logic             snap_v;

  assign active    = instr_start | in_instr_q;
  assign phase_cur = instr_start ? '0 : phase_q;
  assign len_cur   = instr_start ? instr_len : len_q;
  assign samp_ph   = len_cur - LEN_W'(2);
  assign last_ph   = len_cur - LEN_W'(1);
  assign samp_now  = active && (phase_cur == samp_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= '0;
      len_q      <= '0;
      in_instr_q <= 1'b0;
      snap_v     <= 1'b0;
      take_idx   <= '0;
      take_hi    <= 1'b0;
    end else begin
      if (instr_start) begin
        len_q      <= instr_len;
        in_instr_q <= 1'b1;
      end else if (instr_last) begin
        in_instr_q <= 1'b0;
      end
      if (active) phase_q <= phase_cur + LEN_W'(1);
      if (samp_now) begin
        snap_v   <= win_valid && !flag_access;
        take_idx <= win_idx;
        take_hi  <= win_hi;
      end else if (instr_last) begin
        snap_v <= 1'b0;
      end
    end
  end

  assign take = instr_last && snap_v;

  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    instr_start |-> (instr_len >= LEN_W'(MIN_LEN) && instr_len <= LEN_W'(MAX_LEN)));
  p_last_on_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (instr_last == (phase_cur == last_ph)));
  p_access_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_now && flag_access) |=> !take);
endmodule

// File: rtl/irq_ack_ctl.sv
module irq_ack_ctl #(
  parameter int N        = 8,
  parameter int IDX_W    = 3,
  parameter int ACK_LEN  = 8,
  parameter int PSW_STEP = 1,
  parameter int PC_STEP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [IDX_W-1:0] take_idx,
  input  logic             take_hi,
  input  logic             ie_set,
  input  logic             isr_ret,
  output logic             busy,
  output logic             save_status,
  output logic             save_ret_addr,
  output logic [IDX_W-1:0] vec_idx,
  output logic [N-1:0]     flag_clr,
  output logic             ie_q,
  output irq_seq_pkg::svc_lvl_e level
);
  import irq_seq_pkg::*;
  localparam int CNT_W = $clog2(ACK_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic             svc_lo_q, svc_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      vec_idx  <= '0;
      ie_q     <= 1'b0;
      svc_lo_q <= 1'b0;
      svc_hi_q <= 1'b0;
    end else begin
      if (take) begin
        busy    <= 1'b1;
        cnt_q   <= '0;
        vec_idx <= take_idx;
        ie_q    <= 1'b0;
        if (take_hi) svc_hi_q <= 1'b1;
        else         svc_lo_q <= 1'b1;
      end else begin
        if (busy) begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(ACK_LEN - 1)) busy <= 1'b0;
        end
        if (ie_set) ie_q <= 1'b1;
        if (isr_ret && !busy) begin
          if (svc_hi_q) svc_hi_q <= 1'b0;
          else          svc_lo_q <= 1'b0;
        end
      end
    end
  end

  assign level         = cur_level(svc_lo_q, svc_hi_q);
  assign save_status   = busy && (cnt_q == CNT_W'(PSW_STEP));
  assign save_ret_addr = busy && (cnt_q == CNT_W'(PC_STEP));
  assign flag_clr      = (busy && cnt_q == '0) ? ({{(N-1){1'b0}}, 1'b1} << vec_idx) : '0;

  p_ie_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ie_q);
  p_vec_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(vec_idx));
  p_no_take_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !take);
  p_low_only_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_hi) |-> (!svc_lo_q && !svc_hi_q));
  p_hi_not_in_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !svc_hi_q);
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int N        = 8,
  parameter int LEN_W    = 4,
  parameter int MIN_LEN  = 2,
  parameter int MAX_LEN  = 10,
  parameter int ACK_LEN  = 8,
  parameter int PSW_STEP = 1,
  parameter int PC_STEP  = 3,
  localparam int IDX_W   = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_start,
  input  logic [LEN_W-1:0] instr_len,
  input  logic             instr_last,
  input  logic [N-1:0]     irq_flag,
  input  logic [N-1:0]     irq_mask,
  input  logic [N-1:0]     irq_prio,
  input  logic             flag_access,
  input  logic             int_enable_set,
  input  logic             isr_return,
  output logic             ack_busy,
  output logic             save_status,
  output logic             save_ret_addr,
  output logic [IDX_W-1:0] vec_idx,
  output logic [N-1:0]     flag_clr
);
  import irq_seq_pkg::*;

  logic             win_valid, win_hi, take, take_hi, ie_q;
  logic [IDX_W-1:0] win_idx, take_idx;
  svc_lvl_e         level;

  irq_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .flag(irq_flag), .mask(irq_mask), .prio(irq_prio), .ie(ie_q), .level(level),
    .win_valid(win_valid), .win_idx(win_idx), .win_hi(win_hi)
  );

  irq_boundary #(.LEN_W(LEN_W), .IDX_W(IDX_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_bnd (
    .clk(clk), .rst_n(rst_n), .instr_start(instr_start), .instr_len(instr_len),
    .instr_last(instr_last), .flag_access(flag_access), .win_valid(win_valid),
    .win_idx(win_idx), .win_hi(win_hi), .take(take), .take_idx(take_idx), .take_hi(take_hi)
  );

  irq_ack_ctl #(.N(N), .IDX_W(IDX_W), .ACK_LEN(ACK_LEN), .PSW_STEP(PSW_STEP), .PC_STEP(PC_STEP)) u_ack (
    .clk(clk), .rst_n(rst_n), .take(take), .take_idx(take_idx), .take_hi(take_hi),
    .ie_set(int_enable_set), .isr_ret(isr_return), .busy(ack_busy),
    .save_status(save_status), .save_ret_addr(save_ret_addr), .vec_idx(vec_idx),
    .flag_clr(flag_clr), .ie_q(ie_q), .level(level)
  );

  p_no_instr_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_busy |-> !instr_start);
  p_win_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (irq_flag[win_idx] && !irq_mask[win_idx]));
  p_clr_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr));
  p_clr_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_busy) |-> (flag_clr != '0));
endmodule

// File: tb/tb_irq_ack_seq.sv
module tb_irq_ack_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_start = 1'b0, instr_last = 1'b0;
  logic [3:0] instr_len = 4'd0;
  logic [7:0] flags = 8'h00, mask = 8'h00, prio = 8'h00;
  logic       flag_access = 1'b0, ie_set = 1'b0, isr_ret = 1'b0;
  logic       ack_busy, save_status, save_ret_addr;
  logic [2:0] vec_idx;
  logic [7:0] flag_clr;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_ack_seq dut (
    .clk(clk), .rst_n(rst_n), .instr_start(instr_start), .instr_len(instr_len),
    .instr_last(instr_last), .irq_flag(flags), .irq_mask(mask), .irq_prio(prio),
    .flag_access(flag_access), .int_enable_set(ie_set), .isr_return(isr_ret),
    .ack_busy(ack_busy), .save_status(save_status), .save_ret_addr(save_ret_addr),
    .vec_idx(vec_idx), .flag_clr(flag_clr)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (flag_clr != 8'h00) flags = flags & ~flag_clr;
  endtask

  task automatic pulse_ie();
    ie_set = 1'b1; tick(); ie_set = 1'b0;
  endtask

  task automatic pulse_ret();
    isr_ret = 1'b1; tick(); isr_ret = 1'b0;
  endtask

  task automatic run_instr(input int len, input int raise_ph, input logic [7:0] src, input int acc_ph);
    instr_len = 4'(len);
    for (int p = 0; p < len; p++) begin
      instr_start = (p == 0);
      instr_last  = (p == len - 1);
      flag_access = (p == acc_ph);
      if (p == raise_ph) flags = flags | src;
      tick();
    end
    instr_start = 1'b0; instr_last = 1'b0; flag_access = 1'b0;
  endtask

  task automatic check_ack(input int idx, input string tag);
    for (int k = 0; k < 8; k++) begin
      check({tag, " R4 busy"}, ack_busy, 1);
      check({tag, " R4 vec"}, vec_idx, idx);
      check({tag, " R4 clr"}, flag_clr, (k == 0) ? (1 << idx) : 0);
      check({tag, " R4 status step"}, save_status, (k == 1));
      check({tag, " R4 addr step"}, save_ret_addr, (k == 3));
      tick();
    end
    check({tag, " R4 end"}, ack_busy, 0);
  endtask

  task automatic t_reset();
    check("R1 busy", ack_busy, 0);
    check("R1 clr", flag_clr, 0);
    check("R1 status", save_status, 0);
    check("R1 addr", save_ret_addr, 0);
    run_instr(4, 0, 8'h01, -1);
    check("R1 R8 disabled no take", ack_busy, 0);
    flags = 8'h00;
  endtask

  task automatic t_basic();
    pulse_ie();
    run_instr(4, 2, 8'h08, -1);
    check("R2 taken len4", ack_busy, 1);
    check_ack(3, "R2 len4");
    pulse_ret();
    pulse_ie();
    run_instr(10, 8, 8'h02, -1);
    check("R2 taken len10", ack_busy, 1);
    check_ack(1, "R2 len10");
    pulse_ret();
  endtask

  task automatic t_late();
    pulse_ie();
    run_instr(4, 3, 8'h10, -1);
    check("R3 final clock not taken", ack_busy, 0);
    run_instr(4, -1, 8'h00, -1);
    check("R3 taken one later", ack_busy, 1);
    check_ack(4, "R3 late");
    pulse_ret();
    pulse_ie();
    run_instr(2, 1, 8'h04, -1);
    check("R3 2-clock final not taken", ack_busy, 0);
    run_instr(4, -1, 8'h00, -1);
    check("R3 after next instr", ack_busy, 1);
    check_ack(2, "R3 short");
    pulse_ret();
    pulse_ie();
    run_instr(2, 0, 8'h40, -1);
    check("R3 2-clock first clock taken", ack_busy, 1);
    check_ack(6, "R3 short first");
    pulse_ret();
  endtask

  task automatic t_mask();
    pulse_ie();
    mask = 8'h20;
    run_instr(4, 0, 8'h20, -1);
    check("R5 masked", ack_busy, 0);
    run_instr(6, -1, 8'h00, -1);
    check("R5 still masked", ack_busy, 0);
    mask = 8'h00;
    run_instr(4, -1, 8'h00, -1);
    check("R5 pending kept", ack_busy, 1);
    check_ack(5, "R5 unmask");
    pulse_ret();
  endtask

  task automatic t_access();
    pulse_ie();
    run_instr(4, 0, 8'h01, 2);
    check("R6 held", ack_busy, 0);
    run_instr(4, -1, 8'h00, -1);
    check("R6 taken next", ack_busy, 1);
    check_ack(0, "R6");
    pulse_ret();
  endtask

  task automatic t_prio();
    pulse_ie();
    prio = 8'h40;
    run_instr(4, 0, 8'h42, -1);
    check("R7 high level first", ack_busy, 1);
    check_ack(6, "R7 hi");
    pulse_ret();
    pulse_ie();
    run_instr(4, -1, 8'h00, -1);
    check_ack(1, "R7 then low");
    pulse_ret();
    prio = 8'h00;
    pulse_ie();
    run_instr(4, 0, 8'h84, -1);
    check_ack(2, "R7 lowest index");
    pulse_ret();
    pulse_ie();
    run_instr(4, -1, 8'h00, -1);
    check_ack(7, "R7 remaining");
    pulse_ret();
  endtask

  task automatic t_nest();
    prio = 8'h20;
    pulse_ie();
    run_instr(4, 0, 8'h08, -1);
    check_ack(3, "R9 outer low");
    run_instr(4, 0, 8'h20, -1);
    check("R8 enable cleared by ack", ack_busy, 0);
    pulse_ie();
    run_instr(4, -1, 8'h00, -1);
    check("R9 high nests in low", ack_busy, 1);
    check_ack(5, "R9 nested");
    pulse_ret();
    pulse_ret();
    prio = 8'h00;
    pulse_ie();
    run_instr(4, 0, 8'h04, -1);
    check_ack(2, "R9 low outer");
    pulse_ie();
    run_instr(4, 0, 8'h10, -1);
    check("R9 same level not nested", ack_busy, 0);
    pulse_ret();
    run_instr(4, -1, 8'h00, -1);
    check("R9 taken after return", ack_busy, 1);
    check_ack(4, "R9 after return");
    pulse_ret();
    prio = 8'h03;
    pulse_ie();
    run_instr(4, 0, 8'h01, -1);
    check_ack(0, "R9 hi outer");
    pulse_ie();
    run_instr(4, 0, 8'h02, -1);
    check("R9 high not nested in high", ack_busy, 0);
    pulse_ret();
    run_instr(4, -1, 8'h00, -1);
    check_ack(1, "R9 high after return");
    pulse_ret();
    prio = 8'h00;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_late();
    t_mask();
    t_access();
    t_prio();
    t_nest();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule